// File: doc/BRIEF.md
# Capacity Learning Qualification Counter

This block sits beside a battery charge accumulator. It counts how many times the cell is charged while no relearn of the learned maximum capacity has taken place, and it decides when a discharge has been clean enough to justify a relearn. Each qualifying charge event adds one to an 8-bit count. Once enough events have piled up, a flag tells the host that the stored capacity figure can no longer be trusted. A relearn clears both the count and the flag.

Trickle charging at the top of the charge curve would otherwise run the count up on every top-up. To prevent this, the block compares the present available charge with 94 % of the learned capacity and lets only one charge event through while the charge stays at or above that level. A learning window opens when the cell is near full and discharging. It closes with a one-cycle update strobe when the first end-of-discharge indication rises. The window is abandoned if a charge event, a sub-zero temperature or excess self-discharge occurs inside it.

Top module: `cap_learn_qual`

## Requirements
- R1: A cycle with `chg_evt` high and `nac` below the threshold (`nac`×100 < `lmd`×94) raises `inacc_cnt` by one on the next clock.
- R2: While `nac`×100 ≥ `lmd`×94, only the first `chg_evt` cycle is counted. Counting resumes after at least one clocked cycle with `nac` below the threshold.
- R3: `inacc_cnt` stops at 255 and never wraps to zero.
- R4: `cap_inacc` goes high on the clock that brings `inacc_cnt` to 64 and stays high until an update strobe.
- R5: The clock that raises `lmd_upd` also sets `inacc_cnt` to 0 and `cap_inacc` to 0.
- R6: A cycle with the threshold met, `dsg_act` high and no voiding input arms the learning window. A rising edge of `edv_first` (high now, low in the previous cycle) seen while armed, with no voiding input in that cycle, produces `lmd_upd` high for exactly one clock on the next edge.
- R7: A `chg_evt` cycle disarms the window, so no strobe follows without a fresh arming.
- R8: A cycle with `temp_ok` low disarms the window.
- R9: A cycle with `sd_over` high disarms the window.
- R10: While `rst_n` is low, and for two clocks after it is released, `inacc_cnt` is 0, `cap_inacc` is 0 and `lmd_upd` is 0.
- R11: Equality `nac`×100 = `lmd`×94 counts as at-or-above the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chg_evt | input | 1 | One valid-charge event in this cycle |
| nac | input | 16 | Present nominal available charge |
| lmd | input | 16 | Learned maximum capacity |
| dsg_act | input | 1 | Discharge in progress |
| edv_first | input | 1 | First end-of-discharge indication, level |
| temp_ok | input | 1 | Temperature at or above 0 °C |
| sd_over | input | 1 | Self-discharge reduction above 6 % |
| inacc_cnt | output | 8 | Charge events since the last relearn |
| cap_inacc | output | 1 | Capacity figure is inaccurate |
| lmd_upd | output | 1 | One-clock strobe: relearn capacity now |

## Verification
The assertions take all inputs to be synchronous to `clk` and stable around its rising edge. They also take `edv_first` to be a level whose rises are counted edge to edge, not a pre-made pulse. The stimulus meets both conditions by changing every input only on the falling edge. It holds inputs idle while the internal reset release runs, and it uses a behavioural model clocked on the same rising edge as the design. Random phases keep `nac` close to the 94 % boundary. This lets arming, the near-full gate and the voiding inputs collide often.

// File: rtl/clq_pkg.sv
package clq_pkg;
  // Threshold ratio: near full when nac*THR_DEN >= lmd*THR_NUM
  localparam int unsigned THR_NUM = 94;
  localparam int unsigned THR_DEN = 100;

  typedef enum logic {
    GATE_OPEN  = 1'b0,
    GATE_SPENT = 1'b1
  } gate_e;
endpackage

// File: rtl/clq_thresh_cmp.sv
module clq_thresh_cmp
  import clq_pkg::*;
#(
  parameter int CAP_W = 16
) (
  input  logic [CAP_W-1:0] nac_i,
  input  logic [CAP_W-1:0] lmd_i,
  output logic             near_full_o
);
  localparam int PROD_W = CAP_W + $clog2(THR_DEN) + 1;

  logic [PROD_W-1:0] nac_x;
  logic [PROD_W-1:0] lmd_x;

  always_comb begin
    nac_x       = PROD_W'(nac_i) * PROD_W'(THR_DEN);
    lmd_x       = PROD_W'(lmd_i) * PROD_W'(THR_NUM);
    near_full_o = (nac_x >= lmd_x);
  end
endmodule

// File: rtl/clq_gate.sv
module clq_gate
  import clq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic near_full_i,
  output logic inc_o
);
  gate_e gate_q, gate_d;
  logic  gate_en;

  always_comb begin
    inc_o   = chg_i && !(near_full_i && (gate_q == GATE_SPENT));
    gate_d  = gate_q;
    if (!near_full_i)
      gate_d = GATE_OPEN;
    else if (chg_i)
      gate_d = GATE_SPENT;
    gate_en = (gate_d != gate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= GATE_OPEN;
    else if (gate_en)
      gate_q <= gate_d;
  end

  // R2
  gate_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_i && near_full_i) ##1 (chg_i && near_full_i) |-> !inc_o);
endmodule

// File: rtl/clq_count.sv
module clq_count #(
  parameter int CNT_W   = 8,
  parameter int FLAG_AT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FLAG_VAL = CNT_W'(FLAG_AT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             at_max;
  logic             cnt_en;

  always_comb begin
    at_max = (cnt_q == CNT_MAX);
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr_i) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (inc_i && !at_max) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d == FLAG_VAL)
        flag_d = 1'b1;
    end
    cnt_en = clr_i || (inc_i && !at_max);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/clq_learn.sv
module clq_learn (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic near_full_i,
  input  logic dsg_i,
  input  logic edv_i,
  input  logic temp_ok_i,
  input  logic sd_over_i,
  output logic upd_now_o,
  output logic upd_o
);
  logic edv_q;
  logic armed_q, armed_d;
  logic upd_q;
  logic void_c;
  logic edv_rise;

  always_comb begin
    void_c    = chg_i || !temp_ok_i || sd_over_i;
    edv_rise  = edv_i && !edv_q;
    upd_now_o = armed_q && edv_rise && !void_c;
    armed_d   = armed_q;
    if (void_c || upd_now_o)
      armed_d = 1'b0;
    else if (near_full_i && dsg_i)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edv_q   <= 1'b0;
      armed_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      edv_q   <= edv_i;
      armed_q <= armed_d;
      upd_q   <= upd_now_o;
    end
  end

  assign upd_o = upd_q;

  // R7
  chg_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> !armed_q);

  // R8
  cold_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_ok_i |=> !armed_q);

  // R9
  sd_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_over_i |=> !armed_q);
endmodule

// File: rtl/cap_learn_qual.sv
module cap_learn_qual #(
  parameter int CAP_W   = 16,
  parameter int CNT_W   = 8,
  parameter int FLAG_AT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_evt,
  input  logic [CAP_W-1:0] nac,
  input  logic [CAP_W-1:0] lmd,
  input  logic             dsg_act,
  input  logic             edv_first,
  input  logic             temp_ok,
  input  logic             sd_over,
  output logic [CNT_W-1:0] inacc_cnt,
  output logic             cap_inacc,
  output logic             lmd_upd
);
  localparam int RS_STAGES = 2;

  logic [RS_STAGES-1:0] rs_q;
  logic                 rst_sync_n;
  logic                 near_full;
  logic                 inc;
  logic                 upd_now;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= '0;
    else
      rs_q <= {rs_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rs_q[RS_STAGES-1];

  clq_thresh_cmp #(.CAP_W(CAP_W)) cmp_i (
    .nac_i       (nac),
    .lmd_i       (lmd),
    .near_full_o (near_full)
  );

  clq_gate gate_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .chg_i       (chg_evt),
    .near_full_i (near_full),
    .inc_o       (inc)
  );

  clq_learn learn_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .chg_i       (chg_evt),
    .near_full_i (near_full),
    .dsg_i       (dsg_act),
    .edv_i       (edv_first),
    .temp_ok_i   (temp_ok),
    .sd_over_i   (sd_over),
    .upd_now_o   (upd_now),
    .upd_o       (lmd_upd)
  );

  clq_count #(.CNT_W(CNT_W), .FLAG_AT(FLAG_AT)) count_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc_i  (inc),
    .clr_i  (upd_now),
    .cnt_o  (inacc_cnt),
    .flag_o (cap_inacc)
  );

  // R4
  flag_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_inacc == (inacc_cnt >= CNT_W'(FLAG_AT)));

  // R5
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lmd_upd |-> (inacc_cnt == '0 && !cap_inacc));

  // R6
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lmd_upd |=> !lmd_upd);
endmodule

// File: tb/cap_learn_qual_tb_top.sv
`timescale 1ns/1ps
module cap_learn_qual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chg_evt, dsg_act, edv_first, temp_ok, sd_over;
  logic [15:0] nac, lmd;
  logic [7:0]  inacc_cnt;
  logic        cap_inacc, lmd_upd;

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R10";
  bit    done = 1'b0;

  // reference state
  int m_cnt, m_rel;
  bit m_flag, m_upd, m_armed, m_gate, m_edvd;

  always #2.5 clk = ~clk;

  cap_learn_qual dut_i (
    .clk(clk), .rst_n(rst_n), .chg_evt(chg_evt), .nac(nac), .lmd(lmd),
    .dsg_act(dsg_act), .edv_first(edv_first), .temp_ok(temp_ok),
    .sd_over(sd_over), .inacc_cnt(inacc_cnt), .cap_inacc(cap_inacc),
    .lmd_upd(lmd_upd)
  );

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped on the rising edge
  always @(posedge clk) begin
    if (!rst_n || m_rel < 2) begin
      if (rst_n) m_rel++;
      m_cnt = 0; m_flag = 0; m_upd = 0; m_armed = 0; m_gate = 0; m_edvd = 0;
    end else begin
      longint a, b;
      bit nf, vd, up, inc;
      a   = longint'(nac) * 100;
      b   = longint'(lmd) * 94;
      nf  = (a >= b);
      vd  = chg_evt || !temp_ok || sd_over;
      up  = m_armed && edv_first && !m_edvd && !vd;
      inc = chg_evt && !(nf && m_gate);
      if (!nf) m_gate = 0; else if (chg_evt) m_gate = 1;
      if (up) begin
        m_cnt = 0; m_flag = 0;
      end else if (inc && m_cnt < 255) begin
        m_cnt++;
        if (m_cnt == 64) m_flag = 1;
      end
      if (vd || up) m_armed = 0; else if (nf && dsg_act) m_armed = 1;
      m_upd  = up;
      m_edvd = edv_first;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, inacc_cnt, m_cnt, "count vs model");
      chk(phase, cap_inacc, m_flag, "flag vs model");
      chk(phase, lmd_upd, m_upd, "strobe vs model");
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    chg_evt = 1'b1; tick(1);
    chg_evt = 1'b0; tick(1);
  endtask

  task automatic arm_then_low();
    nac = 16'd1000; lmd = 16'd1000; dsg_act = 1'b1; tick(1);
    nac = 16'd500; tick(1);
  endtask

  initial begin
    rst_n = 1'b0; chg_evt = 0; nac = 0; lmd = 0; dsg_act = 0;
    edv_first = 0; temp_ok = 1; sd_over = 0;
    tick(3);
    // R10 reset state
    chk("R10", inacc_cnt, 0, "count in reset");
    chk("R10", cap_inacc, 0, "flag in reset");
    chk("R10", lmd_upd, 0, "strobe in reset");
    rst_n = 1'b1;
    tick(4);

    phase = "R1";
    nac = 16'd0; lmd = 16'd1000;
    for (int i = 0; i < 10; i++) pulse();
    chk("R1", inacc_cnt, 10, "count after 10 low charges");

    phase = "R2";
    nac = 16'd1000;
    for (int i = 0; i < 5; i++) pulse();
    chk("R2", inacc_cnt, 11, "only first near-full charge");
    nac = 16'd900; tick(1);
    nac = 16'd1000; pulse();
    chk("R2", inacc_cnt, 12, "gate reopened after dip");

    phase = "R11";
    lmd = 16'd100; nac = 16'd93;
    pulse(); pulse();
    nac = 16'd94;
    pulse(); pulse();
    chk("R11", inacc_cnt, 15, "equality treated as near full");

    phase = "R4";
    nac = 16'd0; lmd = 16'd1000;
    for (int i = 0; i < 48; i++) pulse();
    chk("R4", inacc_cnt, 63, "count before flag");
    chk("R4", cap_inacc, 0, "flag low at 63");
    pulse();
    chk("R4", cap_inacc, 1, "flag high at 64");

    phase = "R3";
    for (int i = 0; i < 200; i++) pulse();
    chk("R3", inacc_cnt, 255, "saturated count");

    phase = "R6";
    arm_then_low();
    edv_first = 1'b1; tick(1);
    chk("R6", lmd_upd, 1, "strobe after edge while armed");
    chk("R5", inacc_cnt, 0, "count cleared by update");
    chk("R5", cap_inacc, 0, "flag cleared by update");
    tick(1);
    chk("R6", lmd_upd, 0, "strobe one clock only");
    edv_first = 1'b0; tick(2);

    phase = "R7";
    arm_then_low();
    pulse();
    edv_first = 1'b1; tick(1);
    chk("R7", lmd_upd, 0, "charge voided window");
    edv_first = 1'b0; tick(2);

    phase = "R8";
    arm_then_low();
    temp_ok = 1'b0; tick(1); temp_ok = 1'b1;
    edv_first = 1'b1; tick(1);
    chk("R8", lmd_upd, 0, "cold voided window");
    edv_first = 1'b0; tick(2);

    phase = "R9";
    arm_then_low();
    sd_over = 1'b1; tick(1); sd_over = 1'b0;
    edv_first = 1'b1; tick(1);
    chk("R9", lmd_upd, 0, "self-discharge voided window");
    edv_first = 1'b0; tick(2);

    phase = "R6 random";
    lmd = 16'd1000;
    for (int i = 0; i < 6000; i++) begin
      chg_evt   = ($urandom_range(0, 99) < 15);
      nac       = 16'($urandom_range(880, 1000));
      dsg_act   = ($urandom_range(0, 99) < 70);
      if ($urandom_range(0, 99) < 10) edv_first = ~edv_first;
      temp_ok   = ($urandom_range(0, 99) < 96);
      sd_over   = ($urandom_range(0, 99) < 3);
      tick(1);
    end
    chg_evt = 0; tick(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule